// File: doc/BRIEF.md
# Bit-Serial Cyclic Hamming Encoder

This block turns 11-bit messages into 15-bit systematic codewords of a cyclic code that corrects any single error. Message bits arrive one per clock, highest-degree bit first, on cycles where the bit-valid input is high. Cycles where it is low are skipped entirely. A four-stage division register built from the generator polynomial g(x) = 1 + x + x^4 accumulates the parity remainder while the message bits are shifted into a parallel holding register.

After the eleventh accepted bit, the block shows the complete codeword on a parallel output and raises a ready flag for exactly one cycle. The word counter then wraps, so the first bit of the next message may be presented in that same ready cycle. Typical use is behind a serial receiver or deserialiser that feeds a framed bit stream, with the ready pulse used as the load strobe of the consumer.

Top module: `cyc_ham_serial_enc`

## Requirements
- R1: A synchronous reset clears the ready flag, the word position and the codeword output to zero. The first accepted bit after reset is treated as the first bit of a new word, even if reset arrived partway through a word.
- R2: The codeword is laid out as {message[10:0], parity[3:0]}. The first message bit accepted lands in codeword bit 14, and the last one lands in codeword bit 4.
- R3: The parity field codeword[3:0] equals x^4·m(x) mod g(x), where g(x) = 1 + x + x^4 and bit i holds the coefficient of x^i. Every codeword shown with ready high is therefore a multiple of g(x).
- R4: While bit-valid is low, the data input is ignored. The codeword output and the word position do not change.
- R5: Ready is high in the cycle after the clock edge that accepts the eleventh bit of a word, and it is low in every other cycle.
- R6: A new word may start in the ready cycle with no idle gap. The remainder is cleared at each word start, so back-to-back words are encoded independently.
- R7: The block accepts a different message length, parity width and generator through parameters. Elaboration rejects settings where the generator lacks its constant or leading term, where the message is shorter than 2 bits, or where the code length exceeds 2^P - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Serial message bit, highest degree first |
| word_ready | output | 1 | One-cycle pulse: codeword is complete |
| codeword | output | 15 | {message, parity} of the word just finished |

## Verification
Every accepted bit goes through one register stage, so the codeword and the ready pulse are due one edge after the eleventh accepted bit. The bench drives inputs on falling edges and checks the result at the very next falling edge, which falls inside that ready cycle. For the skipped cycles, the codeword is read at the falling edge after each idle cycle and compared with its value before the gap. After a reset, the outputs are checked at the first falling edge that follows the reset edge. Back-to-back words are driven starting at the same falling edge where the previous result is checked, so the ready cycle doubles as the next word's first input cycle.

// File: rtl/cyc_ham_pkg.sv
package cyc_ham_pkg;
   // Default code: (15,11) cyclic Hamming code, g(x) = 1 + x + x^4
   localparam int          DEF_MSG_BITS = 11;
   localparam int          DEF_PAR_BITS = 4;
   localparam logic [4:0]  DEF_GEN_POLY = 5'b10011;
endpackage

// File: rtl/cyc_ham_word_ctr.sv
module cyc_ham_word_ctr #(
   parameter int MSG_BITS = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic adv,
   output logic at_first,
   output logic at_last
);
   localparam int CW = (MSG_BITS > 2) ? $clog2(MSG_BITS) : 1;
   localparam logic [CW-1:0] LAST = CW'(MSG_BITS - 1);

   logic [CW-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (rst)
         pos_q <= '0;
      else if (adv)
         pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
   end

   assign at_first = (pos_q == '0);
   assign at_last  = (pos_q == LAST);

   // Reset returns the word position to the first bit
   assert_pos_reset_R1: assert property (@(posedge clk) rst |=> (pos_q == '0));
   // An idle cycle leaves the word position untouched
   assert_pos_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(pos_q));
endmodule

// File: rtl/cyc_ham_div_reg.sv
module cyc_ham_div_reg #(
   parameter int           PAR_BITS = 4,
   parameter logic [PAR_BITS:0] GEN_POLY = 5'b10011
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                adv,
   input  logic                restart,
   input  logic                din,
   output logic [PAR_BITS-1:0] rem
);
   logic [PAR_BITS-1:0] rem_q;
   logic [PAR_BITS-1:0] base;
   logic [PAR_BITS-1:0] rem_d;
   logic                fb;

   // A new word starts its division from an empty remainder
   assign base = restart ? '0 : rem_q;
   assign fb   = din ^ base[PAR_BITS-1];

   generate
      for (genvar s = 0; s < PAR_BITS; s++) begin : g_stage
         if (s == 0) begin : g_head
            assign rem_d[s] = fb & GEN_POLY[0];
         end else begin : g_tap
            assign rem_d[s] = base[s-1] ^ (fb & GEN_POLY[s]);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         rem_q <= '0;
      else if (adv)
         rem_q <= rem_d;
   end

   assign rem = rem_q;

   // The remainder is frozen while no bit is accepted
   assert_rem_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(rem_q));
endmodule

// File: rtl/cyc_ham_msg_sr.sv
module cyc_ham_msg_sr #(
   parameter int MSG_BITS = 11
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                adv,
   input  logic                din,
   output logic [MSG_BITS-1:0] msg
);
   logic [MSG_BITS-1:0] sr_q;

   always_ff @(posedge clk) begin
      if (rst)
         sr_q <= '0;
      else if (adv)
         sr_q <= {sr_q[MSG_BITS-2:0], din};
   end

   assign msg = sr_q;

   // The newest accepted bit sits at the lowest message position
   assert_msg_entry_R2: assert property (@(posedge clk) disable iff (rst)
      adv |=> (sr_q[0] == $past(din)));
endmodule

// File: rtl/cyc_ham_serial_enc.sv
module cyc_ham_serial_enc
   import cyc_ham_pkg::*;
#(
   parameter int MSG_BITS = DEF_MSG_BITS,
   parameter int PAR_BITS = DEF_PAR_BITS,
   parameter logic [PAR_BITS:0] GEN_POLY = DEF_GEN_POLY,
   localparam int CW_BITS = MSG_BITS + PAR_BITS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               bit_valid,
   input  logic               bit_in,
   output logic               word_ready,
   output logic [CW_BITS-1:0] codeword
);
   // Elaboration-time parameter checks (R7)
   generate
      if (MSG_BITS < 2) begin : g_bad_len_R7
         $error("message length must be at least 2");
      end
      if (PAR_BITS < 2) begin : g_bad_par_R7
         $error("parity width must be at least 2");
      end
      if ((GEN_POLY[0] != 1'b1) || (GEN_POLY[PAR_BITS] != 1'b1)) begin : g_bad_gen_R7
         $error("generator needs constant and leading terms");
      end
      if (CW_BITS > (2 ** PAR_BITS) - 1) begin : g_bad_n_R7
         $error("code length exceeds 2^P - 1");
      end
   endgenerate

   logic                word_first;
   logic                word_last;
   logic [MSG_BITS-1:0] msg;
   logic [PAR_BITS-1:0] par;
   logic                ready_q;

   cyc_ham_word_ctr #(.MSG_BITS(MSG_BITS)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .adv      (bit_valid),
      .at_first (word_first),
      .at_last  (word_last)
   );

   cyc_ham_div_reg #(.PAR_BITS(PAR_BITS), .GEN_POLY(GEN_POLY)) u_div (
      .clk     (clk),
      .rst     (rst),
      .adv     (bit_valid),
      .restart (word_first),
      .din     (bit_in),
      .rem     (par)
   );

   cyc_ham_msg_sr #(.MSG_BITS(MSG_BITS)) u_msg (
      .clk (clk),
      .rst (rst),
      .adv (bit_valid),
      .din (bit_in),
      .msg (msg)
   );

   always_ff @(posedge clk) begin
      if (rst)
         ready_q <= 1'b0;
      else
         ready_q <= bit_valid & word_last;
   end

   assign word_ready = ready_q;
   assign codeword   = {msg, par};

   // Remainder of a word by the generator, for checking only
   function automatic logic [PAR_BITS-1:0] syndrome_of(input logic [CW_BITS-1:0] w);
      logic [CW_BITS-1:0] d;
      d = w;
      for (int b = CW_BITS - 1; b >= PAR_BITS; b--) begin
         if (d[b])
            d = d ^ (CW_BITS'(GEN_POLY) << (b - PAR_BITS));
      end
      return d[PAR_BITS-1:0];
   endfunction

   assert_out_reset_R1: assert property (@(posedge clk)
      rst |=> (!word_ready && (codeword == '0)));
   assert_word_divisible_R3: assert property (@(posedge clk) disable iff (rst)
      word_ready |-> (syndrome_of(codeword) == '0));
   assert_ready_single_R5: assert property (@(posedge clk) disable iff (rst)
      word_ready |=> !word_ready);
   assert_ready_wraps_R6: assert property (@(posedge clk) disable iff (rst)
      word_ready |-> word_first);
endmodule

// File: tb/test_cyc_ham_serial_enc.sv
module test_cyc_ham_serial_enc;
   localparam int K = 11;
   localparam int N = 15;
   localparam int NVEC = 6;

   // {message, expected codeword}, worked by hand
   localparam logic [K+N-1:0] VEC [NVEC] = '{
      {11'h000, 15'h0000},
      {11'h001, 15'h0013},
      {11'h002, 15'h0026},
      {11'h003, 15'h0035},
      {11'h400, 15'h4009},
      {11'h7FF, 15'h7FFF}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         bit_valid = 1'b0;
   logic         bit_in = 1'b0;
   logic         word_ready;
   logic [N-1:0] codeword;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  early = 1'b0;
   bit  done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   cyc_ham_serial_enc i_cyc_ham_serial_enc (
      .clk        (clk),
      .rst        (rst),
      .bit_valid  (bit_valid),
      .bit_in     (bit_in),
      .word_ready (word_ready),
      .codeword   (codeword)
   );

   // Independent reference: long division of m(x)*x^4 by 1 + x + x^4
   function automatic logic [N-1:0] ref_cw(input logic [K-1:0] m);
      logic [N-1:0] d;
      d = {m, 4'b0000};
      for (int b = N - 1; b >= 4; b--)
         if (d[b]) d = d ^ (15'b000_0000_0001_0011 << (b - 4));
      return {m, d[3:0]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the falling edge inside the ready cycle
   task automatic send_word(input logic [K-1:0] m, input int gap);
      logic [N-1:0] hold;
      early = 1'b0;
      for (int i = K - 1; i >= 0; i--) begin
         bit_valid = 1'b1;
         bit_in    = m[i];
         @(negedge clk);
         if (i > 0) begin
            if (word_ready) early = 1'b1;
            for (int g = 0; g < gap; g++) begin
               hold      = codeword;
               bit_valid = 1'b0;
               bit_in    = ~m[i];
               @(negedge clk);
               chk("R4 codeword held while idle", 32'(codeword), 32'(hold));
               if (word_ready) early = 1'b1;
            end
         end
      end
   endtask

   task automatic idle_cycle();
      bit_valid = 1'b0;
      bit_in    = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: outputs cleared by reset
      chk("R1 ready after reset", 32'(word_ready), 32'd0);
      chk("R1 codeword after reset", 32'(codeword), 32'd0);

      // R2/R3/R5: hand-worked vector table
      for (int v = 0; v < NVEC; v++) begin
         send_word(VEC[v][K+N-1:N], 0);
         chk("R5 ready due after last bit", 32'(word_ready), 32'd1);
         chk("R5 no early ready", 32'(early), 32'd0);
         chk("R2 R3 table codeword", 32'(codeword), 32'(VEC[v][N-1:0]));
         idle_cycle();
         chk("R5 ready lasts one cycle", 32'(word_ready), 32'd0);
      end

      // R2: first accepted bit lands in codeword bit 14
      send_word(11'h400, 0);
      chk("R2 first bit at top", 32'(codeword[14]), 32'd1);
      idle_cycle();

      // R4: idle gaps with toggling data between every bit
      send_word(11'h5A3, 2);
      chk("R4 ready after gapped word", 32'(word_ready), 32'd1);
      chk("R5 no early ready with gaps", 32'(early), 32'd0);
      chk("R4 gapped codeword", 32'(codeword), 32'(ref_cw(11'h5A3)));
      idle_cycle();

      // R1: reset partway through a word
      for (int i = 0; i < 5; i++) begin
         bit_valid = 1'b1;
         bit_in    = 1'b1;
         @(negedge clk);
      end
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 ready cleared mid-word", 32'(word_ready), 32'd0);
      chk("R1 codeword cleared mid-word", 32'(codeword), 32'd0);
      send_word(11'h2C9, 0);
      chk("R1 ready after restart", 32'(word_ready), 32'd1);
      chk("R1 fresh word after reset", 32'(codeword), 32'(ref_cw(11'h2C9)));
      idle_cycle();

      // R3/R6: every message, back to back with no idle cycle
      for (int m = 0; m < 2048; m++) begin
         send_word(11'(m), 0);
         chk("R6 back-to-back ready", 32'(word_ready), 32'd1);
         chk("R3 R6 back-to-back codeword", 32'(codeword), 32'(ref_cw(11'(m))));
      end
      idle_cycle();
      chk("R5 ready low after sweep", 32'(word_ready), 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule